// File: doc/BRIEF.md
# Key-Protected Watchdog Reset Timer

This block is a watchdog counter with a small register bus. Its control state (counter enable, reset enable, match value, status, counter restart) can only be changed by a write that directly follows a two-key unlock. Software first writes 0xBABA to the first-key register and then 0xEB10 to the second-key register. The next bus write, if it targets a protected register, is accepted. Any write at all then re-locks the block, so every protected write needs its own fresh key pair.

When counting is enabled, the counter advances by one each clock. When the count equals the match value, a sticky status flag and an interrupt-pending flag are set. If reset generation is also enabled, a system reset request pulse of a fixed length is produced. The interrupt flag has its own clear register, which is not protected. The live count can be read at any time.

Register map (3-bit word address): 0 first key, 1 second key, 2 control, 3 match value, 4 live count (read only), 5 status, 6 interrupt clear, 7 counter restart. In the control register, bit 0 enables counting and bit 1 enables the reset request. Reads of the key and restart registers return 0. Reads of address 6 return the interrupt-pending flag in bit 0. Reads of the status register return the status flag in bit 0.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the count, match value, control bits, status flag, interrupt flag and reset request are all 0, and the key sequencer is locked.
- R2: Writing 0xBABA to address 0 and then 0xEB10 to address 1, as the two writes directly before a write to address 2, 3, 5 or 7, makes that write take effect.
- R3: A write to address 2, 3, 5 or 7 made while the sequencer is not unlocked leaves every register unchanged.
- R4: A wrong value at either key address, a second key written without a correct first key directly before it, or any other write between the keys or between the second key and the protected write, leaves the sequencer locked.
- R5: An unlock is used up by the single protected write that follows it. A second protected write without new keys is ignored.
- R6: With control bit 0 set, the count at address 4 rises by exactly one per clock. With bit 0 clear, it holds.
- R7: The status flag (address 5, bit 0) becomes 1 one clock after a cycle in which the count equals the match value while control bit 0 is set. It then stays 1 until it is cleared.
- R8: An unlocked write to address 5 with data bit 0 equal to 0 clears the status flag. An unlocked write with data bit 0 equal to 1 leaves it unchanged.
- R9: An unlocked write to address 7 sets the count to 0 at that clock edge, taking priority over the increment.
- R10: When the status flag and control bit 1 are both 1, `wdt_rst_req` is high for exactly RST_CYCLES clocks, starting one clock after that condition becomes true. This happens once each time the condition becomes true.
- R11: `wdt_irq` is set together with the status flag. It is cleared by a write with data bit 0 set to address 6, which needs no keys and does not change the status flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 3 | Word address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | System reset request pulse |
| wdt_irq | output | 1 | Watchdog interrupt-pending flag |

## Verification
On every cycle, the assertions check the following:
- A protected write always leaves the sequencer locked.
- The unlocked state is only entered from a correct second key.
- A restart zeroes the count, and a disabled counter holds.
- The match value moves only on a granted write.
- The status flag rises only after a real match and is sticky.
- A reset pulse starts only from the armed condition and never runs longer than RST_CYCLES.

Only the bench's scenarios can show the following:
- That a full key sequence with the right values and order is actually granted.
- The exact clock on which status, interrupt and reset request rise for a given match value, including a match value of 0.
- That the interrupt clear is independent of the status flag.
- That random malformed key sequences never open the block.

// File: rtl/keyed_wdog_pkg.sv
// Shared constants and types for the key-protected watchdog.
// Assumes a 3-bit word address space on the register bus.
package keyed_wdog_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [15:0] KEY_FIRST  = 16'hBABA;
    localparam logic [15:0] KEY_SECOND = 16'hEB10;

    typedef enum logic [ADDR_W-1:0] {
        A_KEY1    = 3'd0,
        A_KEY2    = 3'd1,
        A_CTRL    = 3'd2,
        A_LIMIT   = 3'd3,
        A_COUNT   = 3'd4,
        A_STATUS  = 3'd5,
        A_IRQCLR  = 3'd6,
        A_RESTART = 3'd7
    } wd_addr_e;

    typedef enum logic [1:0] {
        LK_LOCKED = 2'd0,
        LK_HALF   = 2'd1,
        LK_OPEN   = 2'd2
    } lock_e;

    // True for registers whose writes need a fresh unlock.
    function automatic logic is_protected(input logic [ADDR_W-1:0] a);
        return (a == A_CTRL) || (a == A_LIMIT) ||
               (a == A_STATUS) || (a == A_RESTART);
    endfunction

endpackage

// File: rtl/wdog_keyseq.sv
// Two-key unlock sequencer. It grants exactly one protected write, and
// only when the two writes directly before it were the first key and then
// the second key, with correct values. Every other write re-locks.
// Assumes at most one bus write per cycle.
module wdog_keyseq
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              prot_go
);

    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

    lock_e state;
    logic  prot_wr;

    // Decode whether the current write targets a protected register.
    always_comb prot_wr = wr && is_protected(addr);

    // Grant the write only from the fully unlocked state.
    always_comb prot_go = prot_wr && (state == LK_OPEN);

    // Advance the sequence on key writes; any other write re-locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LK_LOCKED;
        end else if (wr) begin
            case (addr)
                A_KEY1:  state <= (wdata == K1) ? LK_HALF : LK_LOCKED;
                A_KEY2:  state <= (state == LK_HALF && wdata == K2) ? LK_OPEN : LK_LOCKED;
                default: state <= LK_LOCKED;
            endcase
        end
    end

    // R5: a protected write always uses up the unlock.
    p_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> (state == LK_LOCKED));

    // R2/R4: the open state is only reached from a correct second key.
    p_open_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == LK_OPEN) |-> $past(wr && addr == A_KEY2 && wdata == K2 && state == LK_HALF));

endmodule

// File: rtl/wdog_core.sv
// Counter, match detector, sticky status flag and interrupt-pending flag.
// Assumes the write enables are already qualified by the key sequencer,
// except the interrupt clear, which is unprotected.
module wdog_core #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              limit_we,
    input  logic              stat_we,
    input  logic              restart_we,
    input  logic              irqclr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        ctrl,
    output logic [CNT_W-1:0]  limit,
    output logic [CNT_W-1:0]  count,
    output logic              status,
    output logic              irq
);

    logic hit;

    // A match counts only while the counter is enabled.
    always_comb hit = ctrl[0] && (count == limit);

    // Hold the control bits and the match value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl  <= '0;
            limit <= '0;
        end else begin
            if (ctrl_we)  ctrl  <= wdata[1:0];
            if (limit_we) limit <= wdata[CNT_W-1:0];
        end
    end

    // The counter: restart wins over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (restart_we) count <= '0;
        else if (ctrl[0])    count <= count + 1'b1;
    end

    // Sticky status flag: set on a match, cleared by a granted write of 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                     status <= 1'b0;
        else if (hit)                   status <= 1'b1;
        else if (stat_we && !wdata[0])  status <= 1'b0;
    end

    // Interrupt-pending flag: set on a match, cleared by its own register.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (hit)       irq <= 1'b1;
        else if (irqclr_we) irq <= 1'b0;
    end

    p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        restart_we |=> (count == '0));

    p_hold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !restart_we) |=> $stable(count));

    p_limit_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_we |=> $stable(limit));

    p_status_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(ctrl[0] && count == limit));

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !stat_we) |=> status);

endmodule

// File: rtl/wdog_rstpulse.sv
// Produces a reset-request pulse of RST_CYCLES clocks each time the arm
// condition becomes true. Assumes RST_CYCLES >= 1.
module wdog_rstpulse #(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic rst_req
);

    localparam int unsigned CW = $clog2(RST_CYCLES + 1);

    logic          arm_q;
    logic [CW-1:0] left;
    logic [CW-1:0] hi_run;

    // Remember the previous arm level so that its rising edge can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm;
    end

    // Load the pulse length on a new arm, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)              left <= '0;
        else if (arm && !arm_q)  left <= CW'(RST_CYCLES);
        else if (left != '0)     left <= left - 1'b1;
    end

    always_comb rst_req = (left != '0);

    // Checker-only count of consecutive high cycles already seen.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hi_run <= '0;
        else if (!rst_req)                    hi_run <= '0;
        else if (hi_run != CW'(RST_CYCLES))   hi_run <= hi_run + 1'b1;
    end

    p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(arm));

    p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (hi_run < CW'(RST_CYCLES)));

endmodule

// File: rtl/keyed_wdog.sv
// Top level of the key-protected watchdog. It decodes bus writes into
// granted register updates and muxes the read data.
// Assumes CNT_W <= DATA_W and one bus access per cycle.
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_req,
    output logic              wdt_irq
);

    logic             prot_go;
    logic [1:0]       ctrl;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] count;
    logic             status;
    logic             irq;
    logic             arm;

    wdog_keyseq #(.DATA_W(DATA_W)) u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .prot_go (prot_go)
    );

    wdog_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (prot_go && bus_addr == A_CTRL),
        .limit_we   (prot_go && bus_addr == A_LIMIT),
        .stat_we    (prot_go && bus_addr == A_STATUS),
        .restart_we (prot_go && bus_addr == A_RESTART),
        .irqclr_we  (bus_wr && bus_addr == A_IRQCLR && bus_wdata[0]),
        .wdata      (bus_wdata),
        .ctrl       (ctrl),
        .limit      (limit),
        .count      (count),
        .status     (status),
        .irq        (irq)
    );

    // Arm the reset pulse when the status flag and the reset enable are both set.
    always_comb arm = status && ctrl[1];

    wdog_rstpulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .rst_req (wdt_rst_req)
    );

    always_comb wdt_irq = irq;

    // Read data mux for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = DATA_W'(ctrl);
            A_LIMIT:  bus_rdata = DATA_W'(limit);
            A_COUNT:  bus_rdata = DATA_W'(count);
            A_STATUS: bus_rdata = DATA_W'(status);
            A_IRQCLR: bus_rdata = DATA_W'(irq);
            default:  bus_rdata = '0;
        endcase
    end

    p_ctrl_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(prot_go && bus_addr == A_CTRL) |=> $stable(ctrl));

endmodule

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/100ps
module keyed_wdog_bench;
    import keyed_wdog_pkg::*;

    localparam int unsigned RSTC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;
    logic        wdt_irq;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    keyed_wdog #(.DATA_W(32), .CNT_W(32), .RST_CYCLES(RSTC)) u_keyed_wdog (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.2;
        v = bus_rdata;
    endtask

    task automatic unlock();
        wr(A_KEY1, 32'hBABA);
        wr(A_KEY2, 32'hEB10);
    endtask

    task automatic pw(input logic [2:0] a, input logic [31:0] d);
        unlock();
        wr(a, d);
    endtask

    // Bench model: only a clean sequence opens the block.
    function automatic bit exp_grant(input int s);
        return s == 0;
    endfunction

    // Bench model of the reset request n clocks after the enabling write.
    function automatic bit exp_rst(input int n, input int lim, input bit ren);
        return ren && (n >= lim + 2) && (n < lim + 2 + int'(RSTC));
    endfunction

    // Prepare a clean state, enable with the given mode and track outputs clock by clock.
    task automatic run_match(input int lim, input logic [1:0] mode);
        logic [31:0] v;
        pw(A_CTRL, 0);
        pw(A_STATUS, 0);
        wr(A_IRQCLR, 1);
        pw(A_RESTART, 1);
        pw(A_LIMIT, lim);
        pw(A_CTRL, {30'b0, mode});
        for (int n = 0; n <= lim + int'(RSTC) + 6; n++) begin
            if (n > 0) @(negedge clk);
            rd(A_COUNT, v);
            check("R6 count", v, mode[0] ? n : 0);
            rd(A_STATUS, v);
            check("R7 status", v, (mode[0] && n >= lim + 1) ? 1 : 0);
            check("R10 rst_req", {31'b0, wdt_rst_req}, {31'b0, exp_rst(n, lim, mode[0] && mode[1])});
        end
        check("R11 irq set", {31'b0, wdt_irq}, {31'b0, mode[0]});
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] cur_lim;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_COUNT, v);  check("R1 count", v, 0);
        rd(A_LIMIT, v);  check("R1 limit", v, 0);
        rd(A_CTRL, v);   check("R1 ctrl", v, 0);
        rd(A_STATUS, v); check("R1 status", v, 0);
        check("R1 rst_req", {31'b0, wdt_rst_req}, 0);
        check("R1 irq", {31'b0, wdt_irq}, 0);

        // R3 protected writes while locked
        wr(A_CTRL, 3);
        wr(A_LIMIT, 32'h55);
        repeat (3) @(negedge clk);
        rd(A_CTRL, v);  check("R3 ctrl", v, 0);
        rd(A_LIMIT, v); check("R3 limit", v, 0);
        rd(A_COUNT, v); check("R3 count", v, 0);

        // R4 keys in the wrong order
        wr(A_KEY2, 32'hEB10); wr(A_KEY1, 32'hBABA); wr(A_LIMIT, 32'h11);
        rd(A_LIMIT, v); check("R4 order", v, 0);

        // R2 clean unlock
        pw(A_LIMIT, 32'h77);
        rd(A_LIMIT, v); check("R2 grant", v, 32'h77);
        cur_lim = 32'h77;

        // R2/R4/R5 random key sequences
        for (int i = 0; i < 24; i++) begin
            int s;
            logic [31:0] val;
            s = $urandom_range(0, 5);
            val = $urandom;
            case (s)
                0: unlock();
                1: begin wr(A_KEY1, 32'hBABA ^ $urandom_range(1, 255)); wr(A_KEY2, 32'hEB10); end
                2: begin wr(A_KEY1, 32'hBABA); wr(A_KEY2, 32'hEB10 ^ $urandom_range(1, 255)); end
                3: begin wr(A_KEY2, 32'hEB10); wr(A_KEY1, 32'hBABA); end
                4: begin wr(A_KEY1, 32'hBABA); wr(A_IRQCLR, 0); wr(A_KEY2, 32'hEB10); end
                default: begin unlock(); wr(A_IRQCLR, 0); end
            endcase
            wr(A_LIMIT, val);
            if (exp_grant(s)) cur_lim = val;
            rd(A_LIMIT, v); check(exp_grant(s) ? "R2 random grant" : "R4 random reject", v, cur_lim);
            wr(A_LIMIT, ~val);
            rd(A_LIMIT, v); check("R5 single use", v, cur_lim);
        end

        // R7/R10/R11 directed corner cases and random match values
        run_match(0, 2'b11);
        run_match(15, 2'b11);
        run_match(5, 2'b01);
        run_match(4, 2'b10);
        for (int i = 0; i < 4; i++) run_match($urandom_range(1, 30), 2'b11);

        // R8 status write rules, R11 independent interrupt clear
        run_match(3, 2'b01);
        pw(A_STATUS, 1);
        rd(A_STATUS, v); check("R8 write one keeps", v, 1);
        wr(A_STATUS, 0);
        rd(A_STATUS, v); check("R8 locked clear ignored", v, 1);
        wr(A_IRQCLR, 1);
        check("R11 irq cleared", {31'b0, wdt_irq}, 0);
        rd(A_IRQCLR, v); check("R11 irq readback", v, 0);
        rd(A_STATUS, v); check("R11 status kept", v, 1);
        pw(A_STATUS, 0);
        rd(A_STATUS, v); check("R8 cleared", v, 0);

        // R9 restart
        pw(A_CTRL, 0);
        pw(A_LIMIT, 32'h1000);
        pw(A_CTRL, 1);
        repeat (20) @(negedge clk);
        pw(A_RESTART, 1);
        rd(A_COUNT, v); check("R9 restart zero", v, 0);
        @(negedge clk);
        rd(A_COUNT, v); check("R9 restart then count", v, 1);
        pw(A_CTRL, 0);
        rd(A_COUNT, v);
        @(negedge clk);
        check("R6 hold", bus_rdata, v);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule